// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox with Status Flags

This block sits between a host processor bus and a small slave controller. It carries one byte at a time each way. The host sees two locations, selected by its address line `a0`. The even location (`a0` = 0) is the data register. The odd location (`a0` = 1) is the status register. A host write to either location loads the slave's input buffer. The level of `a0` during that write is recorded in a flag, so the slave firmware can tell a command byte (odd address) from a data byte (even address). A host read of the even location returns the byte the slave last placed in the output buffer.

The slave has the following operations:
- take the input byte, which clears Input Full;
- post an output byte, which sets Output Full;
- hold, clear, toggle or set each of its two user flags.

The host polls the status register for handshaking. It writes only when Input Full is clear. It reads data only when Output Full is set.

Host accesses are sampled on the block clock. Each clock cycle in which `cs_n` and a strobe are both low counts as one access. The external reset is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `host_slave_mailbox`

## Requirements
- R1: After reset, the four status flags are zero and a host status read returns 0x00.
- R2: A host write with `a0`=0 stores the byte in the input buffer, sets Input Full (status bit 1) and clears the command flag (status bit 3). On the following cycle the slave sees the byte on `s_in_data`.
- R3: A host write with `a0`=1 also stores the byte in the input buffer and sets Input Full, but it sets the command flag (status bit 3) to 1.
- R4: `s_in_take` clears Input Full. A take while Input Full is already clear leaves the flag clear and leaves `s_in_data` holding the previous byte.
- R5: A host write while Input Full is set replaces the buffered byte and keeps Input Full set.
- R6: `s_out_put` stores `s_out_data` and sets Output Full (status bit 0). A host read with `a0`=0 returns that byte and clears Output Full.
- R7: A host status read returns {4'b0000, F1, F0, IBF, OBF} and changes no flag and no buffer.
- R8: The user flag F0 (status bit 2) changes only through `s_f0_op`, which is encoded 0 hold, 1 clear, 2 toggle, 3 set. No host access alters F0.
- R9: `s_f1_op` acts on the command flag with the same encoding as `s_f0_op`. If a host write occurs in the same cycle, the host write decides the new value.
- R10: When a buffer's set event and its clear event fall in the same cycle, the full flag ends set and the buffer holds the new byte. For the input buffer these events are a host write and a slave take. For the output buffer they are a slave put and a host data read.
- R11: Strobes with `cs_n` high have no effect on any flag or buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| a0 | input | 1 | Host address line: 0 selects data, 1 selects status |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (data buffer or status) |
| s_in_take | input | 1 | Slave takes the input byte |
| s_in_data | output | 8 | Input buffer contents |
| s_out_put | input | 1 | Slave posts a byte to the output buffer |
| s_out_data | input | 8 | Byte posted by the slave |
| s_f0_op | input | 2 | F0 operation: 0 hold, 1 clear, 2 toggle, 3 set |
| s_f1_op | input | 2 | Command flag operation, same encoding |
| s_status | output | 4 | Status flags {F1, F0, IBF, OBF} for the slave |

## Verification
The hardest states to reach are same-cycle collisions:
- a host write against a slave clear of the command flag;
- a host write against a slave take;
- a slave put against a host data read.

To create each collision, the bench drives both sides' strobes on the same falling edge and holds them for exactly one cycle. It then reads status and data through the normal ports. Stale-data behaviour is reached by issuing a second take after the flag has already cleared and confirming that the byte on `s_in_data` is unchanged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    FOP_HOLD   = 2'd0,
    FOP_CLEAR  = 2'd1,
    FOP_TOGGLE = 2'd2,
    FOP_SET    = 2'd3
  } flag_op_e;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_F0  = 2;
  localparam int ST_F1  = 3;
  localparam int ST_NUM = 4;
endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec (
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic a0,
  output logic h_wr,
  output logic h_rd_data,
  output logic h_rd_stat
);
  logic sel;
  logic rd_any;

  always_comb begin
    sel       = ~cs_n;
    h_wr      = sel & ~wr_n;
    rd_any    = sel & ~rd_n & wr_n;
    h_rd_data = rd_any & ~a0;
    h_rd_stat = rd_any & a0;
  end
endmodule

// File: rtl/mbx_buf.sv
module mbx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic [DW-1:0] put_data,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          full
);
  logic [DW-1:0] data_nxt;
  logic          full_nxt;
  logic          data_en;

  always_comb begin
    data_en  = put;
    data_nxt = put_data;
    if (put)       full_nxt = 1'b1;
    else if (take) full_nxt = 1'b0;
    else           full_nxt = full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      full <= full_nxt;
      if (data_en) data <= data_nxt;
    end
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
  import mbx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld,
  input  logic     ld_val,
  input  flag_op_e op,
  output logic     q
);
  logic q_nxt;

  always_comb begin
    if (ld) q_nxt = ld_val;
    else begin
      unique case (op)
        FOP_CLEAR:  q_nxt = 1'b0;
        FOP_TOGGLE: q_nxt = ~q;
        FOP_SET:    q_nxt = 1'b1;
        default:    q_nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/host_slave_mailbox.sv
module host_slave_mailbox
  import mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              a0,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  input  logic              s_in_take,
  output logic [DW-1:0]     s_in_data,
  input  logic              s_out_put,
  input  logic [DW-1:0]     s_out_data,
  input  logic [1:0]        s_f0_op,
  input  logic [1:0]        s_f1_op,
  output logic [ST_NUM-1:0] s_status
);
  localparam int PAD = DW - ST_NUM;

  logic          rst_q1, rst_q2;
  logic          h_wr, h_rd_data, h_rd_stat;
  logic          ibf, obf, f0, f1;
  logic [DW-1:0] obuf;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  mbx_host_dec u_dec (
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .a0        (a0),
    .h_wr      (h_wr),
    .h_rd_data (h_rd_data),
    .h_rd_stat (h_rd_stat)
  );

  mbx_buf #(.DW(DW)) u_ibuf (
    .clk      (clk),
    .rst_n    (rst_q2),
    .put      (h_wr),
    .put_data (h_wdata),
    .take     (s_in_take),
    .data     (s_in_data),
    .full     (ibf)
  );

  mbx_buf #(.DW(DW)) u_obuf (
    .clk      (clk),
    .rst_n    (rst_q2),
    .put      (s_out_put),
    .put_data (s_out_data),
    .take     (h_rd_data),
    .data     (obuf),
    .full     (obf)
  );

  mbx_flag u_f0 (
    .clk    (clk),
    .rst_n  (rst_q2),
    .ld     (1'b0),
    .ld_val (1'b0),
    .op     (flag_op_e'(s_f0_op)),
    .q      (f0)
  );

  mbx_flag u_f1 (
    .clk    (clk),
    .rst_n  (rst_q2),
    .ld     (h_wr),
    .ld_val (a0),
    .op     (flag_op_e'(s_f1_op)),
    .q      (f1)
  );

  always_comb begin
    s_status         = '0;
    s_status[ST_OBF] = obf;
    s_status[ST_IBF] = ibf;
    s_status[ST_F0]  = f0;
    s_status[ST_F1]  = f1;
    if (h_rd_stat) h_rdata = {{PAD{1'b0}}, s_status};
    else           h_rdata = obuf;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          a0,
  input logic [DW-1:0] h_rdata,
  input logic          s_in_take,
  input logic          s_out_put,
  input logic [1:0]    s_f0_op,
  input logic [1:0]    s_f1_op,
  input logic [3:0]    s_status
);
  logic hw, hrd, hst, armed;

  always_comb begin
    hw  = !cs_n && !wr_n;
    hrd = !cs_n && !rd_n && wr_n && !a0;
    hst = !cs_n && !rd_n && wr_n && a0;
  end

  // enable checks only after the internal reset has released
  logic [1:0] rcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcnt <= 2'd0;
    else if (rcnt != 2'd3) rcnt <= rcnt + 2'd1;
  end
  assign armed = (rcnt == 2'd3);

  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    hw |=> s_status[1]);

  p_f1_capture_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    hw |=> s_status[3] == $past(a0));

  p_ibf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (s_in_take && !hw) |=> !s_status[1]);

  p_obf_set_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    s_out_put |=> s_status[0]);

  p_obf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (hrd && !s_out_put) |=> !s_status[0]);

  p_status_upper_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    hst |-> h_rdata[DW-1:4] == '0);

  p_f0_slave_only_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (s_f0_op == 2'd0) |=> $stable(s_status[2]));

  p_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (cs_n && !s_in_take && !s_out_put && s_f0_op == 2'd0 && s_f1_op == 2'd0)
      |=> $stable(s_status));
endmodule

bind host_slave_mailbox mbx_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .a0        (a0),
  .h_rdata   (h_rdata),
  .s_in_take (s_in_take),
  .s_out_put (s_out_put),
  .s_f0_op   (s_f0_op),
  .s_f1_op   (s_f1_op),
  .s_status  (s_status)
);

// File: tb/host_slave_mailbox_test.sv
module host_slave_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rd_n, wr_n, a0;
  logic [7:0] h_wdata, h_rdata;
  logic       s_in_take, s_out_put;
  logic [7:0] s_in_data, s_out_data;
  logic [1:0] s_f0_op, s_f1_op;
  logic [3:0] s_status;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_slave_mailbox uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .s_in_take(s_in_take),
    .s_in_data(s_in_data), .s_out_put(s_out_put), .s_out_data(s_out_data),
    .s_f0_op(s_f0_op), .s_f1_op(s_f1_op), .s_status(s_status)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1; rd_n = 1; wr_n = 1; a0 = 0; h_wdata = 8'h00;
    s_in_take = 0; s_out_put = 0; s_out_data = 8'h00; s_f0_op = 0; s_f1_op = 0;
  endtask

  task automatic host_write(logic addr, logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = addr; h_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic host_read(logic addr, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = addr;
    #1 d = h_rdata;
    @(negedge clk); idle();
  endtask

  task automatic slave_take();
    @(negedge clk); s_in_take = 1;
    @(negedge clk); idle();
  endtask

  task automatic slave_put(logic [7:0] d);
    @(negedge clk); s_out_put = 1; s_out_data = d;
    @(negedge clk); idle();
  endtask

  task automatic flag_ops(logic [1:0] op0, logic [1:0] op1);
    @(negedge clk); s_f0_op = op0; s_f1_op = op1;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 status", {4'b0, s_status}, 8'h00);
    host_read(1, d);
    chk("R1 host status", d, 8'h00);
  endtask

  task automatic t_data_write();
    host_write(0, 8'h5A);
    chk("R2 in data", s_in_data, 8'h5A);
    chk("R2 status", {4'b0, s_status}, 8'h02);
  endtask

  task automatic t_cmd_write_and_take();
    slave_take();
    chk("R4 ibf cleared", {4'b0, s_status}, 8'h00);
    slave_take();
    chk("R4 stale data", s_in_data, 8'h5A);
    chk("R4 ibf stays clear", {4'b0, s_status}, 8'h00);
    host_write(1, 8'hC3);
    chk("R3 in data", s_in_data, 8'hC3);
    chk("R3 cmd flag", {4'b0, s_status}, 8'h0A);
  endtask

  task automatic t_overwrite();
    host_write(0, 8'h11);
    chk("R5 overwrite data", s_in_data, 8'h11);
    chk("R5 ibf held, F1 low", {4'b0, s_status}, 8'h02);
    slave_take();
  endtask

  task automatic t_out_path();
    logic [7:0] d;
    slave_put(8'h96);
    chk("R6 obf set", {4'b0, s_status}, 8'h01);
    host_read(1, d);
    chk("R7 status read", d, 8'h01);
    chk("R7 no side effect", {4'b0, s_status}, 8'h01);
    host_read(0, d);
    chk("R6 host data", d, 8'h96);
    chk("R6 obf cleared", {4'b0, s_status}, 8'h00);
  endtask

  task automatic t_f0();
    logic [7:0] d;
    flag_ops(3, 0);
    chk("R8 F0 set", {4'b0, s_status}, 8'h04);
    host_write(1, 8'h22);
    chk("R8 host write leaves F0", {4'b0, s_status}, 8'h0E);
    host_read(1, d);
    chk("R7 all flags", d, 8'h0E);
    slave_take();
    flag_ops(2, 2);
    chk("R8/R9 toggle", {4'b0, s_status}, 8'h00);
    flag_ops(2, 3);
    chk("R8/R9 toggle+set", {4'b0, s_status}, 8'h0C);
    flag_ops(1, 1);
    chk("R8/R9 clear", {4'b0, s_status}, 8'h00);
  endtask

  task automatic t_collisions();
    logic [7:0] d;
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = 1; h_wdata = 8'h77; s_f1_op = 1;
    @(negedge clk); idle();
    chk("R9 host write beats clear", {4'b0, s_status}, 8'h0A);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = 0; h_wdata = 8'h78; s_in_take = 1;
    @(negedge clk); idle();
    chk("R10 ibf set wins", {4'b0, s_status}, 8'h02);
    chk("R10 in data new", s_in_data, 8'h78);
    slave_take();
    slave_put(8'hA1);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = 0; s_out_put = 1; s_out_data = 8'hB2;
    #1 d = h_rdata;
    @(negedge clk); idle();
    chk("R10 read old byte", d, 8'hA1);
    chk("R10 obf set wins", {4'b0, s_status}, 8'h01);
    host_read(0, d);
    chk("R10 new byte", d, 8'hB2);
  endtask

  task automatic t_deselect();
    @(negedge clk); cs_n = 1; wr_n = 0; a0 = 1; h_wdata = 8'hEE;
    @(negedge clk); idle();
    chk("R11 no write", {4'b0, s_status}, 8'h00);
    chk("R11 data kept", s_in_data, 8'h78);
    slave_put(8'h3C);
    @(negedge clk); cs_n = 1; rd_n = 0; a0 = 0;
    @(negedge clk); idle();
    chk("R11 no read", {4'b0, s_status}, 8'h01);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_data_write();
    t_cmd_write_and_take();
    t_overwrite();
    t_out_path();
    t_f0();
    t_collisions();
    t_deselect();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule